// File: doc/BRIEF.md
# Flash-to-Serial Configuration Loader

This block sits in a board controller and loads a programmable device from an image held in parallel flash. The flash is read one 16-bit word at a time over a request/valid port, and each word is sent to the target's passive-serial port as single bits on a data line, one bit per rising edge of a generated configuration clock. Before streaming, the loader pulls the target's configuration-request line low. It then waits for the target's status line to return high. After the last word it keeps clocking until the target reports completion or a time limit runs out.

Two image pages exist: page 0 holds the factory image and page 1 holds the user image. When the controller leaves reset, a settings switch picks the page and a load starts at once. After that, a select pushbutton flips the pair of page LEDs between the two pages. Letting go of a configure pushbutton starts a reload from the page the LEDs show at that moment. A done LED reports success and an error LED reports failure. Each stays lit until the next load request.

Top module: `cfg_loader_top`

## Requirements
- R1: Word i of an image (i from 0 to IMG_WORDS-1) is read from flash address PAGE0_BASE+i for page 0 or PAGE1_BASE+i for page 1, in ascending order of i.
- R2: While rst_n is low, tgt_ncfg is 1, tgt_dclk is 0, and done_led and err_led are 0. page_led shows the page chosen by user_page_sw: 0 gives page 0, shown as page_led = 2'b01; 1 gives page 1, shown as 2'b10. The first load after reset uses that page.
- R3: Each debounced press (high-to-low) of sel_btn_n flips page_led between 2'b01 and 2'b10. No other pattern appears.
- R4: Pressing cfg_btn_n and holding it starts nothing. Its debounced release (low-to-high) starts a load from the page shown on page_led in that cycle.
- R5: Each word is sent least significant bit first on tgt_data0, one bit per rising edge of tgt_dclk. tgt_data0 is stable across each rising edge.
- R6: done_led rises when tgt_cdone is high after the last word has been sent. It stays high, with err_led low, until the next load request.
- R7: A level change on either button counts only after it has held for 2^DEB_BITS clock cycles after synchronization. Shorter pulses have no effect.
- R8: Every load starts by driving tgt_ncfg low for exactly NCFG_CYC cycles. No tgt_dclk rising edge occurs while tgt_ncfg is low or before tgt_nstatus is high again.
- R9: If tgt_nstatus goes low while data is streaming or being read, err_led rises and tgt_dclk stops. err_led holds until the next load request, which clears it.
- R10: If tgt_cdone is not high within CDONE_WAIT tgt_dclk rising edges after the last image word, err_led rises.
- R11: flash_req is a single-cycle pulse, one per word, and no new request is issued while a read is outstanding. tgt_dclk does not rise while the loader waits for flash_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low controller reset |
| user_page_sw | input | 1 | Settings switch for the page loaded at reset (0 = factory page 0) |
| sel_btn_n | input | 1 | Page select pushbutton, low when pressed |
| cfg_btn_n | input | 1 | Configure pushbutton, low when pressed |
| flash_req | output | 1 | Single-cycle flash read request |
| flash_addr | output | ADDR_W | Flash word address for the request |
| flash_rvalid | input | 1 | Flash read data valid |
| flash_rdata | input | 16 | Flash read word |
| tgt_ncfg | output | 1 | Target configuration request, active low |
| tgt_nstatus | input | 1 | Target status, low while the target is busy or has failed |
| tgt_cdone | input | 1 | Target configuration complete |
| tgt_dclk | output | 1 | Serial configuration clock |
| tgt_data0 | output | 1 | Serial configuration data |
| page_led | output | 2 | Page indicator: bit 0 lit for page 0, bit 1 lit for page 1 |
| done_led | output | 1 | Load succeeded |
| err_led | output | 1 | Load failed |

## Verification
The bench builds the loader with DEB_BITS=3, IMG_WORDS=4, NCFG_CYC=16, CDONE_WAIT=24, ADDR_W=12, and page bases 0x100 and 0x800. Its flash model answers with a latency of three cycles.

The short debounce window makes both real presses and glitches shorter than the window affordable. The four-word image puts whole-image comparison, the word-boundary stall on every read, and a status drop partway through streaming within a few hundred cycles. The small completion limit lets the timeout be counted edge by edge.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_NCFG,
    ST_WAIT_NST,
    ST_FETCH,
    ST_READ,
    ST_SHIFT,
    ST_TAIL,
    ST_DONE,
    ST_ERROR
  } ld_state_t;
endpackage

// File: rtl/cfg_btn_debounce.sv
module cfg_btn_debounce #(
  parameter int DEB_BITS = 16,
  parameter bit REL_EDGE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_n,
  output logic edge_p
);
  logic s1, s2, stable;
  logic [DEB_BITS-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1     <= 1'b1;
      s2     <= 1'b1;
      stable <= 1'b1;
      cnt    <= '0;
      edge_p <= 1'b0;
    end else begin
      s1     <= btn_n;
      s2     <= s1;
      edge_p <= 1'b0;
      if (s2 == stable) begin
        cnt <= '0;
      end else if (&cnt) begin
        stable <= s2;
        cnt    <= '0;
        edge_p <= REL_EDGE ? s2 : !s2;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_DEB_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (stable != $past(stable)) |-> (stable == $past(s2))); // R7
endmodule

// File: rtl/cfg_word_shifter.sv
module cfg_word_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         ld_valid,
  input  logic [W-1:0] ld_word,
  output logic         ld_ready,
  output logic         dclk,
  output logic         data0,
  output logic         bit_tick,
  output logic         word_done
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     sh;
  logic [CNT_W-1:0] bits_left;
  logic             phase, busy;

  assign ld_ready = !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh        <= '0;
      bits_left <= '0;
      phase     <= 1'b0;
      busy      <= 1'b0;
      dclk      <= 1'b0;
      data0     <= 1'b0;
      bit_tick  <= 1'b0;
      word_done <= 1'b0;
    end else if (clear) begin
      busy      <= 1'b0;
      phase     <= 1'b0;
      dclk      <= 1'b0;
      bit_tick  <= 1'b0;
      word_done <= 1'b0;
    end else begin
      bit_tick  <= 1'b0;
      word_done <= 1'b0;
      if (!busy) begin
        dclk <= 1'b0;
        if (ld_valid) begin
          sh        <= ld_word;
          busy      <= 1'b1;
          phase     <= 1'b0;
          bits_left <= CNT_W'(W);
        end
      end else if (!phase) begin
        data0 <= sh[0];
        sh    <= sh >> 1;
        dclk  <= 1'b0;
        phase <= 1'b1;
      end else begin
        dclk      <= 1'b1;
        bit_tick  <= 1'b1;
        phase     <= 1'b0;
        bits_left <= bits_left - 1'b1;
        if (bits_left == CNT_W'(1)) begin
          busy      <= 1'b0;
          word_done <= 1'b1;
        end
      end
    end
  end

  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ld_valid) |=> !dclk); // R11
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dclk) |-> $stable(data0)); // R5
endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
  import cfg_loader_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int PAGE0_BASE = 0,
  parameter int PAGE1_BASE = 4194304,
  parameter int IMG_WORDS  = 65536,
  parameter int NCFG_CYC   = 16,
  parameter int CDONE_WAIT = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_req,
  input  logic              load_page,
  output logic              flash_req,
  output logic [ADDR_W-1:0] flash_addr,
  input  logic              flash_rvalid,
  input  logic [WORD_W-1:0] flash_rdata,
  output logic              tgt_ncfg,
  input  logic              tgt_nstatus,
  input  logic              tgt_cdone,
  input  logic              sh_ready,
  input  logic              sh_tick,
  input  logic              sh_done,
  output logic              sh_clear,
  output logic              sh_valid,
  output logic [WORD_W-1:0] sh_word,
  output logic              done_led,
  output logic              err_led
);
  localparam int TMR_MAX = (NCFG_CYC > CDONE_WAIT) ? NCFG_CYC : CDONE_WAIT;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int WCNT_W  = $clog2(IMG_WORDS + 1);

  ld_state_t         state;
  logic [TMR_W-1:0]  tmr;
  logic [WCNT_W-1:0] widx;
  logic [ADDR_W-1:0] base;

  assign sh_clear = !(state inside {ST_FETCH, ST_READ, ST_SHIFT, ST_TAIL});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      tmr        <= '0;
      widx       <= '0;
      base       <= '0;
      flash_req  <= 1'b0;
      flash_addr <= '0;
      tgt_ncfg   <= 1'b1;
      sh_valid   <= 1'b0;
      sh_word    <= '0;
      done_led   <= 1'b0;
      err_led    <= 1'b0;
    end else begin
      flash_req <= 1'b0;
      if (load_req) begin
        state    <= ST_NCFG;
        tmr      <= '0;
        widx     <= '0;
        base     <= load_page ? ADDR_W'(PAGE1_BASE) : ADDR_W'(PAGE0_BASE);
        tgt_ncfg <= 1'b0;
        sh_valid <= 1'b0;
        done_led <= 1'b0;
        err_led  <= 1'b0;
      end else begin
        unique case (state)
          ST_NCFG: begin
            tmr <= tmr + 1'b1;
            if (tmr == TMR_W'(NCFG_CYC - 1)) begin
              tgt_ncfg <= 1'b1;
              state    <= ST_WAIT_NST;
            end
          end
          ST_WAIT_NST: if (tgt_nstatus) state <= ST_FETCH;
          ST_FETCH, ST_READ, ST_SHIFT, ST_TAIL: begin
            if (!tgt_nstatus) begin
              state    <= ST_ERROR;
              err_led  <= 1'b1;
              sh_valid <= 1'b0;
            end else if (state == ST_FETCH) begin
              flash_req  <= 1'b1;
              flash_addr <= base + ADDR_W'(widx);
              state      <= ST_READ;
            end else if (state == ST_READ) begin
              if (flash_rvalid) begin
                sh_valid <= 1'b1;
                sh_word  <= flash_rdata;
                widx     <= widx + 1'b1;
                state    <= ST_SHIFT;
              end
            end else if (state == ST_SHIFT) begin
              sh_valid <= 1'b0;
              if (sh_done) begin
                if (widx == WCNT_W'(IMG_WORDS)) begin
                  state <= ST_TAIL;
                  tmr   <= '0;
                end else begin
                  state <= ST_FETCH;
                end
              end
            end else begin
              if (tgt_cdone) begin
                state    <= ST_DONE;
                done_led <= 1'b1;
                sh_valid <= 1'b0;
              end else if (tmr == TMR_W'(CDONE_WAIT)) begin
                state    <= ST_ERROR;
                err_led  <= 1'b1;
                sh_valid <= 1'b0;
              end else begin
                if (sh_tick) tmr <= tmr + 1'b1;
                sh_valid <= sh_ready && !sh_valid;
                sh_word  <= '1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    flash_req |=> !flash_req); // R11
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_led && !load_req) |=> err_led); // R9
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_led && !load_req) |=> (done_led && !err_led)); // R6
endmodule

// File: rtl/cfg_loader_top.sv
module cfg_loader_top
  import cfg_loader_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int PAGE0_BASE = 0,
  parameter int PAGE1_BASE = 4194304,
  parameter int IMG_WORDS  = 65536,
  parameter int NCFG_CYC   = 16,
  parameter int CDONE_WAIT = 1024,
  parameter int DEB_BITS   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              user_page_sw,
  input  logic              sel_btn_n,
  input  logic              cfg_btn_n,
  output logic              flash_req,
  output logic [ADDR_W-1:0] flash_addr,
  input  logic              flash_rvalid,
  input  logic [15:0]       flash_rdata,
  output logic              tgt_ncfg,
  input  logic              tgt_nstatus,
  input  logic              tgt_cdone,
  output logic              tgt_dclk,
  output logic              tgt_data0,
  output logic [1:0]        page_led,
  output logic              done_led,
  output logic              err_led
);
  logic sel_press, cfg_rel;
  logic page_sel, boot_req, load_req;
  logic sh_ready, sh_tick, sh_done, sh_clear, sh_valid;
  logic [WORD_W-1:0] sh_word;

  cfg_btn_debounce #(.DEB_BITS(DEB_BITS), .REL_EDGE(1'b0)) u_sel_deb (
    .clk(clk), .rst_n(rst_n), .btn_n(sel_btn_n), .edge_p(sel_press));

  cfg_btn_debounce #(.DEB_BITS(DEB_BITS), .REL_EDGE(1'b1)) u_cfg_deb (
    .clk(clk), .rst_n(rst_n), .btn_n(cfg_btn_n), .edge_p(cfg_rel));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_sel <= user_page_sw;
      boot_req <= 1'b1;
    end else begin
      boot_req <= 1'b0;
      if (sel_press) page_sel <= !page_sel;
    end
  end

  assign page_led = {page_sel, !page_sel};
  assign load_req = boot_req || cfg_rel;

  cfg_seq_fsm #(
    .ADDR_W(ADDR_W), .PAGE0_BASE(PAGE0_BASE), .PAGE1_BASE(PAGE1_BASE),
    .IMG_WORDS(IMG_WORDS), .NCFG_CYC(NCFG_CYC), .CDONE_WAIT(CDONE_WAIT)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .load_req(load_req), .load_page(page_sel),
    .flash_req(flash_req), .flash_addr(flash_addr),
    .flash_rvalid(flash_rvalid), .flash_rdata(flash_rdata),
    .tgt_ncfg(tgt_ncfg), .tgt_nstatus(tgt_nstatus), .tgt_cdone(tgt_cdone),
    .sh_ready(sh_ready), .sh_tick(sh_tick), .sh_done(sh_done),
    .sh_clear(sh_clear), .sh_valid(sh_valid), .sh_word(sh_word),
    .done_led(done_led), .err_led(err_led));

  cfg_word_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear(sh_clear), .ld_valid(sh_valid),
    .ld_word(sh_word), .ld_ready(sh_ready), .dclk(tgt_dclk),
    .data0(tgt_data0), .bit_tick(sh_tick), .word_done(sh_done));

  AST_SEL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    sel_press |=> (page_led != $past(page_led))); // R3
  AST_LED_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_led && err_led)); // R6
  AST_NCFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!tgt_ncfg && !$fell(tgt_ncfg)) |-> !tgt_dclk); // R8
endmodule

// File: tb/cfg_loader_top_tb_top.sv
`timescale 1ns/1ps
module cfg_loader_top_tb_top;
  localparam int ADDR_W = 12;
  localparam int P0 = 'h100;
  localparam int P1 = 'h800;
  localparam int IMG = 4;
  localparam int NCFG = 16;
  localparam int CWAIT = 24;
  localparam int DEB = 3;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic user_page_sw = 1'b0;
  logic sel_btn_n = 1'b1;
  logic cfg_btn_n = 1'b1;
  logic flash_req;
  logic [ADDR_W-1:0] flash_addr;
  logic flash_rvalid = 1'b0;
  logic [15:0] flash_rdata = '0;
  logic tgt_ncfg;
  logic tgt_nstatus = 1'b0;
  logic tgt_cdone = 1'b0;
  logic tgt_dclk, tgt_data0;
  logic [1:0] page_led;
  logic done_led, err_led;

  always #2.5 clk = !clk;

  cfg_loader_top #(
    .ADDR_W(ADDR_W), .PAGE0_BASE(P0), .PAGE1_BASE(P1), .IMG_WORDS(IMG),
    .NCFG_CYC(NCFG), .CDONE_WAIT(CWAIT), .DEB_BITS(DEB)
  ) dut_i (.*);

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // target and flash models
  logic [1:0] ncfg_d = 2'b00;
  logic nst_kill = 1'b0;
  int kill_at = 0;
  bit cdone_en = 1'b1;
  logic dclk_prev = 1'b0;
  logic ncfg_prev = 1'b1;
  logic [15:0] shreg = '0;
  logic [15:0] got [IMG];
  int bit_cnt = 0, tail_rises = 0, low_run = 0, last_low = 0, ncfg_falls = 0;
  int stall_viol = 0;
  bit pending = 1'b0;
  logic vpipe [LAT];
  logic [ADDR_W-1:0] apipe [LAT];

  function automatic logic [15:0] fw(input logic [ADDR_W-1:0] a);
    return (16'(a) * 16'h2F1B) ^ 16'hC35A;
  endfunction

  initial for (int i = 0; i < LAT; i++) begin vpipe[i] = 1'b0; apipe[i] = '0; end

  always @(negedge clk) begin
    cycles++;
    for (int i = LAT - 1; i > 0; i--) begin vpipe[i] = vpipe[i-1]; apipe[i] = apipe[i-1]; end
    vpipe[0] = (flash_req === 1'b1);
    apipe[0] = flash_addr;
    flash_rvalid = vpipe[LAT-1];
    flash_rdata = vpipe[LAT-1] ? fw(apipe[LAT-1]) : 16'h0;
    if (flash_req === 1'b1) pending = 1'b1;
    if (tgt_dclk === 1'b1 && !dclk_prev && pending) stall_viol++;
    if (flash_rvalid) pending = 1'b0;

    ncfg_d = {ncfg_d[0], (tgt_ncfg === 1'b1)};
    if (tgt_ncfg === 1'b0) begin
      if (ncfg_prev) ncfg_falls++;
      low_run++;
      bit_cnt = 0; tail_rises = 0; tgt_cdone = 1'b0; nst_kill = 1'b0;
    end else begin
      if (low_run != 0) begin last_low = low_run; low_run = 0; end
      if (tgt_dclk === 1'b1 && !dclk_prev) begin
        shreg = {tgt_data0, shreg[15:1]};
        bit_cnt++;
        if (bit_cnt % 16 == 0 && bit_cnt / 16 <= IMG) got[bit_cnt/16 - 1] = shreg;
        if (bit_cnt > IMG * 16) tail_rises++;
        if (bit_cnt == IMG * 16 && cdone_en) tgt_cdone = 1'b1;
        if (kill_at != 0 && bit_cnt == kill_at) nst_kill = 1'b1;
      end
    end
    tgt_nstatus = ncfg_d[1] && !nst_kill;
    dclk_prev = (tgt_dclk === 1'b1);
    ncfg_prev = (tgt_ncfg === 1'b1);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wait_start(input int prev);
    for (int i = 0; i < 2000 && ncfg_falls == prev; i++) tick(1);
  endtask

  task automatic wait_result();
    for (int i = 0; i < 5000 && !(done_led || err_led); i++) tick(1);
  endtask

  task automatic press(input bit which_cfg, input int hold);
    if (which_cfg) cfg_btn_n = 1'b0; else sel_btn_n = 1'b0;
    tick(hold);
    if (which_cfg) cfg_btn_n = 1'b1; else sel_btn_n = 1'b1;
  endtask

  task automatic check_image(input int base, input string tag);
    for (int i = 0; i < IMG; i++)
      check(got[i] == fw(ADDR_W'(base + i)), tag, got[i], fw(ADDR_W'(base + i)));
  endtask

  task automatic t_reset_and_boot(input bit sw);
    int f;
    rst_n = 1'b0; user_page_sw = sw;
    tick(4);
    check(tgt_ncfg === 1'b1 && tgt_dclk === 1'b0, "R2 reset target lines", {tgt_ncfg, tgt_dclk}, 2'b10);
    check(done_led === 1'b0 && err_led === 1'b0, "R2 reset leds", {done_led, err_led}, 0);
    check(page_led === (sw ? 2'b10 : 2'b01), "R2 page_led at reset", page_led, sw ? 2 : 1);
    f = ncfg_falls;
    rst_n = 1'b1;
    wait_start(f);
    wait_result();
    check(done_led === 1'b1 && err_led === 1'b0, "R6 boot done", {done_led, err_led}, 2'b10);
    check_image(sw ? P1 : P0, sw ? "R2 R1 R5 boot image page1" : "R2 R1 R5 boot image page0");
    check(last_low == NCFG, "R8 ncfg low width", last_low, NCFG);
    check(stall_viol == 0, "R11 dclk rose while read pending", stall_viol, 0);
  endtask

  task automatic t_select();
    press(1'b0, 20); tick(20);
    check(page_led === 2'b10, "R3 first select", page_led, 2'b10);
    press(1'b0, 3); tick(20);
    check(page_led === 2'b10, "R7 short glitch ignored", page_led, 2'b10);
    press(1'b0, 20); tick(20);
    check(page_led === 2'b01, "R3 second select", page_led, 2'b01);
    press(1'b0, 20); tick(20);
    check(page_led === 2'b10, "R3 third select", page_led, 2'b10);
  endtask

  task automatic t_cfg_release();
    int f;
    f = ncfg_falls;
    cfg_btn_n = 1'b0;
    tick(40);
    check(ncfg_falls == f, "R4 hold starts nothing", ncfg_falls, f);
    check(done_led === 1'b1, "R4 done kept while held", done_led, 1);
    cfg_btn_n = 1'b1;
    wait_start(f);
    check(ncfg_falls == f + 1, "R4 release starts load", ncfg_falls, f + 1);
    wait_result();
    check(done_led === 1'b1 && err_led === 1'b0, "R6 reload done", {done_led, err_led}, 2'b10);
    check_image(P1, "R4 R1 reload from shown page1");
    check(stall_viol == 0, "R11 stall on reload", stall_viol, 0);
  endtask

  task automatic t_nstatus_drop();
    int f, b;
    kill_at = 20;
    f = ncfg_falls;
    press(1'b1, 20);
    wait_start(f);
    wait_result();
    check(err_led === 1'b1 && done_led === 1'b0, "R9 error on status drop", {done_led, err_led}, 2'b01);
    b = bit_cnt;
    tick(60);
    check(bit_cnt == b, "R9 dclk stopped", bit_cnt, b);
    check(err_led === 1'b1, "R9 error held", err_led, 1);
    kill_at = 0;
  endtask

  task automatic t_cdone_timeout();
    int f;
    cdone_en = 1'b0;
    f = ncfg_falls;
    press(1'b1, 20);
    wait_start(f);
    check(err_led === 1'b0, "R9 new request clears error", err_led, 0);
    wait_result();
    check(err_led === 1'b1 && done_led === 1'b0, "R10 timeout error", {done_led, err_led}, 2'b01);
    check(tail_rises >= CWAIT && tail_rises <= CWAIT + 2, "R10 edges before timeout", tail_rises, CWAIT);
    cdone_en = 1'b1;
    f = ncfg_falls;
    press(1'b1, 20);
    wait_start(f);
    wait_result();
    check(done_led === 1'b1 && err_led === 1'b0, "R10 recovery after timeout", {done_led, err_led}, 2'b10);
  endtask

  initial begin
    t_reset_and_boot(1'b0);
    t_select();
    t_cfg_release();
    t_nstatus_drop();
    t_cdone_timeout();
    t_reset_and_boot(1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule